// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block turns four packed bank configuration words into address windows and tests a physical address against all of them in parallel. Each word carries an enable bit, an 8 MiB aligned base and a three-bit code that selects a power-of-two window size from 4 MiB to 256 MiB. The block reports whether the address falls inside a live window, which bank owns it and the byte offset into that bank.

A bank window is live only while its own enable bit and the controller-wide enable input are both 1. A word carrying the one undecodable size code is reported on a per-bank error flag and never matches. When windows overlap, the lowest-numbered matching bank owns the address and an overlap flag is raised. The decode is combinational and its result is registered once, so outputs follow the inputs sampled at the previous rising clock edge.

Top module: `sdram_bank_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit`, `bank_idx`, `offset`, `size_err` and `overlap` are all zero.
- R2: A bank can match only when bit 0 of its word is 1 and `ctrl_en` is 1; clearing either makes that bank miss.
- R3: The window base is the word with bits [22:0] cleared; an address below the base misses that bank.
- R4: The size code is word bits [19:17]; codes 0..6 give a window of 4 MiB shifted left by the code, so base+size-1 hits and base+size misses.
- R5: Size code 7 never matches; `size_err[i]` is 1 whenever bank i has bit 0 set and code 7.
- R6: When several banks match, `bank_idx` is the lowest matching index and `overlap` is 1; with one or no match `overlap` is 0.
- R7: On a hit, `bank_idx` is the owning bank and `offset` is the address minus its base; on a miss both are zero.
- R8: All outputs reflect the inputs present at the previous rising clock edge, so a changed bank word or enable takes effect one cycle later.
- R9: Word bits [22:20] and [16:1] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller-wide enable |
| bank_cfg | input | NBANK*32 | Bank words, bank i at bits [32*i+31:32*i] |
| addr | input | 32 | Physical address to decode |
| hit | output | 1 | Address lies in a live bank window |
| bank_idx | output | 2 | Index of the owning bank |
| offset | output | 32 | Address minus owning bank base |
| size_err | output | NBANK | Per-bank undecodable size flag |
| overlap | output | 1 | More than one bank matched |

## Verification
The size-error flag and the overlap resolution can fire in the same cycle: one bank carries code 7 while two other banks claim the same window. The bench provokes this both in a directed case and through random words whose bases are drawn from a narrow range, so collisions and code 7 are frequent. Each cycle it judges all five outputs together against a reference function, checking that the faulty bank never wins the priority and that the lowest valid match is chosen.

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder #(
  parameter int NBANK     = 4,
  parameter int AW        = 32,
  parameter int BASE_LSB  = 23,
  parameter int CODE_LSB  = 17,
  parameter int MIN_SHIFT = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_en,
  input  logic [NBANK*AW-1:0] bank_cfg,
  input  logic [AW-1:0]       addr,
  output logic                hit,
  output logic [((NBANK > 1) ? $clog2(NBANK) : 1)-1:0] bank_idx,
  output logic [AW-1:0]       offset,
  output logic [NBANK-1:0]    size_err,
  output logic                overlap
);
  localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [NBANK-1:0] match, bad;
  logic [AW-1:0]    diff [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [AW-1:0] word, base;
    logic [2:0]    code;
    assign word    = bank_cfg[g*AW +: AW];
    assign base    = {word[AW-1:BASE_LSB], {BASE_LSB{1'b0}}};
    assign code    = word[CODE_LSB +: 3];
    assign diff[g] = addr - base;
    assign bad[g]  = word[0] & (code == 3'd7);
    assign match[g] = ctrl_en & word[0] & (code != 3'd7) & (addr >= base)
                    & ((diff[g] >> (MIN_SHIFT + int'(code))) == '0);
  end

  logic [IW-1:0] sel_idx;
  logic [AW-1:0] sel_off;

  always_comb begin
    sel_idx = '0;
    sel_off = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_idx = IW'(i);
        sel_off = diff[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      bank_idx <= '0;
      offset   <= '0;
      size_err <= '0;
      overlap  <= 1'b0;
    end else begin
      hit      <= |match;
      bank_idx <= sel_idx;
      offset   <= sel_off;
      size_err <= bad;
      overlap  <= $countones(match) > 1;
    end
  end
endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk #(
  parameter int NBANK    = 4,
  parameter int AW       = 32,
  parameter int CODE_LSB = 17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl_en,
  input logic [NBANK*AW-1:0] bank_cfg,
  input logic                hit,
  input logic [((NBANK > 1) ? $clog2(NBANK) : 1)-1:0] bank_idx,
  input logic [AW-1:0]       offset,
  input logic [NBANK-1:0]    size_err,
  input logic                overlap
);
  assert_disabled_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !hit);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (offset == '0 && bank_idx == '0));

  assert_overlap_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> hit);

  for (genvar g = 0; g < NBANK; g++) begin : g_chk
    assert_bad_code_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_cfg[g*AW] && bank_cfg[g*AW+CODE_LSB +: 3] == 3'd7)
      |=> (size_err[g] && !(hit && int'(bank_idx) == g)));
    assert_no_flag_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_cfg[g*AW] |=> !size_err[g]);
  end
endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(
  .NBANK(NBANK), .AW(AW), .CODE_LSB(CODE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bank_cfg(bank_cfg),
  .hit(hit), .bank_idx(bank_idx), .offset(offset),
  .size_err(size_err), .overlap(overlap)
);

// File: tb/sdram_bank_decoder_test.sv
module sdram_bank_decoder_test;
  logic         clk = 0;
  logic         rst_n;
  logic         ctrl_en;
  logic [127:0] bank_cfg;
  logic [31:0]  addr;
  logic         hit;
  logic [1:0]   bank_idx;
  logic [31:0]  offset;
  logic [3:0]   size_err;
  logic         overlap;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sdram_bank_decoder uut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bank_cfg(bank_cfg),
    .addr(addr), .hit(hit), .bank_idx(bank_idx), .offset(offset),
    .size_err(size_err), .overlap(overlap)
  );

  function automatic logic [31:0] mkword(input logic [8:0] base_hi, input logic [2:0] code,
                                         input logic en, input logic [31:0] junk);
    logic [31:0] w;
    w = junk & 32'h0071_FFFE;
    w[31:23] = base_hi;
    w[19:17] = code;
    w[0] = en;
    return w;
  endfunction

  task automatic model(input logic [127:0] cfg, input logic en, input logic [31:0] a,
                       output logic e_hit, output logic [1:0] e_idx,
                       output logic [31:0] e_off, output logic [3:0] e_err,
                       output logic e_ovl);
    int n = 0;
    e_hit = 0; e_idx = 0; e_off = 0; e_err = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      longint base, size;
      w = cfg[i*32 +: 32];
      base = longint'(w & 32'hFF80_0000);
      size = longint'(64'h40_0000) << w[19:17];
      e_err[i] = w[0] && (w[19:17] == 3'd7);
      if (en && w[0] && w[19:17] != 3'd7 && longint'(a) >= base && longint'(a) < base + size) begin
        n++;
        if (!e_hit) begin
          e_hit = 1;
          e_idx = 2'(i);
          e_off = 32'(longint'(a) - base);
        end
      end
    end
    e_ovl = (n > 1);
  endtask

  task automatic check_out(input string tag, input logic e_hit, input logic [1:0] e_idx,
                           input logic [31:0] e_off, input logic [3:0] e_err, input logic e_ovl);
    checks++;
    if (hit !== e_hit || bank_idx !== e_idx || offset !== e_off ||
        size_err !== e_err || overlap !== e_ovl) begin
      fails++;
      $display("FAIL %s: got hit=%0b idx=%0d off=%h err=%b ovl=%0b, expected hit=%0b idx=%0d off=%h err=%b ovl=%0b",
               tag, hit, bank_idx, offset, size_err, overlap,
               e_hit, e_idx, e_off, e_err, e_ovl);
    end
  endtask

  task automatic apply(input string tag, input logic [127:0] cfg, input logic en,
                       input logic [31:0] a);
    logic e_hit, e_ovl;
    logic [1:0] e_idx;
    logic [31:0] e_off;
    logic [3:0] e_err;
    @(negedge clk);
    bank_cfg = cfg; ctrl_en = en; addr = a;
    model(cfg, en, a, e_hit, e_idx, e_off, e_err, e_ovl);
    @(posedge clk);
    #2;
    check_out(tag, e_hit, e_idx, e_off, e_err, e_ovl);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] cfg;
    logic [31:0] w0;
    void'($urandom(32'd4711));
    rst_n = 0; ctrl_en = 1; addr = 32'h0100_0000;
    cfg = '0;
    cfg[31:0] = mkword(9'd2, 3'd1, 1'b1, 32'h0);
    bank_cfg = cfg;
    repeat (3) @(posedge clk);
    #2;
    check_out("R1 in reset", 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1;

    w0 = mkword(9'd2, 3'd1, 1'b1, 32'h0);
    cfg = '0; cfg[31:0] = w0;
    apply("R7 base hit", cfg, 1, 32'h0100_0000);
    apply("R4 last byte hit", cfg, 1, 32'h017F_FFFF);
    apply("R4 past end miss", cfg, 1, 32'h0180_0000);
    apply("R3 below base miss", cfg, 1, 32'h00FF_FFFF);
    apply("R2 global off", cfg, 0, 32'h0100_0010);
    cfg[0] = 1'b0;
    apply("R2 bank off", cfg, 1, 32'h0100_0010);
    cfg[31:0] = mkword(9'd2, 3'd7, 1'b1, 32'h0);
    apply("R5 code seven", cfg, 1, 32'h0100_0010);
    cfg[31:0] = mkword(9'd0, 3'd6, 1'b1, 32'h0);
    apply("R4 256MiB top", cfg, 1, 32'h0FFF_FFFF);
    cfg = '0;
    cfg[31:0]   = mkword(9'd8, 3'd7, 1'b1, 32'h0);
    cfg[63:32]  = mkword(9'd8, 3'd2, 1'b1, 32'h0);
    cfg[95:64]  = mkword(9'd8, 3'd3, 1'b1, 32'h0);
    cfg[127:96] = mkword(9'd40, 3'd0, 1'b1, 32'h0);
    apply("R6 overlap with R5 error", cfg, 1, 32'h0400_1234);
    apply("R6 single match", cfg, 1, 32'h0500_0000);
    cfg[31:0]  = mkword(9'd8, 3'd7, 1'b1, 32'hFFFF_FFFF);
    cfg[63:32] = mkword(9'd8, 3'd2, 1'b1, 32'hFFFF_FFFF);
    apply("R9 ignored bits", cfg, 1, 32'h0400_1234);
    cfg[127:96] = mkword(9'd511, 3'd6, 1'b1, 32'h0);
    apply("R8 new word next cycle", cfg, 1, 32'hFFFF_FFF0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      int pick;
      for (int i = 0; i < 4; i++) begin
        logic [2:0] c;
        c = ($urandom % 6 == 0) ? 3'd7 : 3'($urandom % 7);
        cfg[i*32 +: 32] = mkword(9'($urandom % 24), c, ($urandom % 5) != 0, $urandom);
      end
      pick = $urandom % 4;
      a = (cfg[pick*32 +: 32] & 32'hFF80_0000) + ($urandom % 32'h1200_0000) - 32'h0010_0000;
      apply("R8 random", cfg, ($urandom % 4) != 0, a);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule